// File: doc/BRIEF.md
# Eight-Lane Bonded Serial Frame Transmitter

This block sends a framed byte stream over a group of parallel bit-serial lanes that share one bit clock. Every character on a lane is a low start bit followed by eight data bits, least significant first, with no stop bit. Up to one byte per lane leaves in each 9-bit character slot, so a group of up to eight bytes costs one character time instead of eight.

A frame is given as a byte stream with a valid/ready handshake and a marker on the final byte. The transmitter wraps it in 0x7E flag bytes, escapes any payload byte that could be mistaken for a flag or an escape, and deals the resulting bytes across the lanes in order, starting each slot at lane 0. Every frame begins in a fresh slot. A slot that holds fewer bytes than there are lanes leaves the unused lanes at the idle level. The block is used where a receiver can recover each lane on its own from its start bits, so no separate clock or frame strobe wire is needed.

Top module: `bonded_lane_tx`

## Requirements
- R1: Out of reset and whenever `busy` is low, every bit of `lane_out` is high (idle level).
- R2: A character on a lane is one low start bit and then eight data bits, least significant bit first; no stop bit is inserted, so the next start bit may directly follow the eighth data bit.
- R3: Every frame on the lanes begins with one 0x7E byte and ends with one 0x7E byte.
- R4: A payload byte 0x7E is sent as the two bytes 0x7D, 0x5E.
- R5: A payload byte 0x7D is sent as the two bytes 0x7D, 0x5D (escape, then the byte XOR 0x20); all other payload bytes pass unchanged.
- R6: Bytes after stuffing are placed on lanes 0, 1, 2, ... in order, each slot starts at lane 0, and the opening flag of every frame sits on lane 0 of a new slot.
- R7: In a slot with fewer bytes than lanes, the unused (higher) lanes stay high for the whole slot and send no start bit.
- R8: All lanes used in a slot drive their start bits in the same bit clock.
- R9: With the payload offered without gaps, slots follow each other with no idle bit, so a frame of n bytes after stuffing occupies ceil(n/8) x 9 bit times (11 bytes: 18, 19 bytes: 27).
- R10: `in_ready` is high only when the stuffing stage takes a payload byte in that cycle; it is low while a flag or the second byte of an escape pair is emitted, and payload offered with gaps is still delivered once each, in order (partial slots are sent out rather than held).
- R11: `busy` is high from the acceptance of a frame's opening flag until the last bit of its last slot has left the lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one lane bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A payload byte is offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the final one of its frame |
| in_ready | output | 1 | Payload byte is taken at this clock edge |
| lane_out | output | LANES | Serial lane levels, lane 0 in bit 0 |
| busy | output | 1 | A frame is being stuffed, grouped or shifted out |

## Verification
A wrong stuffing state shows at the lanes within one slot as a missing, doubled or unescaped byte, which the scoreboard sees when it decodes that slot. A wrong slot fill count or lane pointer shows as a byte on the wrong lane, a gap inside a slot or a start bit on an unused lane, visible nine bit times after the slot is loaded at the latest. A wrong shift counter shows as an idle bit between back-to-back slots or a slot cut short, which the slot start timing of the long frames exposes, and a wrong busy term shows as busy falling while a lane is still low.

// File: rtl/blt_pkg.sv
// Package: shared constants and types for the bonded lane transmitter.
// Assumes bytes are 8 bits and a character is one start bit plus one byte.
package blt_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          CHAR_BITS  = 1 + BYTE_W;
    localparam int          CNT_W      = $clog2(CHAR_BITS + 1);
    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ESC_BYTE   = 8'h7D;
    localparam logic [7:0]  ESC_FLIP   = 8'h20;

    typedef enum logic [1:0] {
        FR_OPEN  = 2'd0,
        FR_DATA  = 2'd1,
        FR_ESC   = 2'd2,
        FR_CLOSE = 2'd3
    } fr_state_t;
endpackage

// File: rtl/blt_framer.sv
// Framer: wraps each frame in flag bytes and escapes flag/escape payload
// bytes. Output is a byte stream with valid/ready and a close marker.
// Assumes out_valid may not depend on out_ready (it does not), so the
// downstream ready may depend on out_valid without a loop.
module blt_framer
    import blt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_close,
    input  logic       out_ready,
    output logic       active
);
    fr_state_t  state_q;
    logic [7:0] held_q;
    logic       held_last_q;
    logic       is_special;

    assign is_special = (in_data == FLAG_BYTE) || (in_data == ESC_BYTE);
    assign active     = (state_q != FR_OPEN);

    // Output byte selection per framing state.
    always_comb begin
        out_valid = 1'b0;
        out_byte  = FLAG_BYTE;
        out_close = 1'b0;
        in_ready  = 1'b0;
        case (state_q)
            FR_OPEN: begin
                out_valid = in_valid;
                out_byte  = FLAG_BYTE;
            end
            FR_DATA: begin
                out_valid = in_valid;
                out_byte  = is_special ? ESC_BYTE : in_data;
                in_ready  = out_ready;
            end
            FR_ESC: begin
                out_valid = 1'b1;
                out_byte  = held_q;
            end
            default: begin
                out_valid = 1'b1;
                out_byte  = FLAG_BYTE;
                out_close = 1'b1;
            end
        endcase
    end

    // Framing state advance on each accepted output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FR_OPEN;
            held_q      <= '0;
            held_last_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            case (state_q)
                FR_OPEN: state_q <= FR_DATA;
                FR_DATA: begin
                    if (is_special) begin
                        held_q      <= in_data ^ ESC_FLIP;
                        held_last_q <= in_last;
                        state_q     <= FR_ESC;
                    end else if (in_last) begin
                        state_q <= FR_CLOSE;
                    end
                end
                FR_ESC:  state_q <= held_last_q ? FR_CLOSE : FR_DATA;
                default: state_q <= FR_OPEN;
            endcase
        end
    end
endmodule

// File: rtl/blt_slot_packer.sv
// Slot packer: gathers stuffed bytes into a slot of LANES bytes and hands
// the slot to the serializer when it is full, when the frame has closed,
// or when no byte is on offer. Assumes ser_free is high in the last bit
// cycle of the running slot so slots can follow without a gap.
module blt_slot_packer
    import blt_pkg::*;
#(
    parameter int LANES = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    input  logic                  in_close,
    output logic                  in_ready,
    input  logic                  ser_free,
    output logic                  launch,
    output logic [LANES*8-1:0]    slot_bytes,
    output logic [CW-1:0]         slot_used,
    output logic                  sealed
);
    logic [7:0]    buf_q [LANES];
    logic [CW-1:0] count_q;
    logic          full;

    assign full      = (count_q == CW'(LANES));
    assign launch    = ser_free && (count_q != '0) && (full || sealed || !in_valid);
    assign in_ready  = !full && !sealed && !launch;
    assign slot_used = count_q;

    // Fill pointer and seal flag bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            sealed  <= 1'b0;
        end else if (launch) begin
            count_q <= '0;
            sealed  <= 1'b0;
        end else if (in_valid && in_ready) begin
            count_q <= count_q + 1'b1;
            sealed  <= in_close;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_slot
            // Capture the byte destined for lane g.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    buf_q[g] <= '0;
                end else if (in_valid && in_ready && (count_q == CW'(g))) begin
                    buf_q[g] <= in_byte;
                end
            end
            assign slot_bytes[g*8 +: 8] = buf_q[g];
        end
    endgenerate
endmodule

// File: rtl/blt_slot_serializer.sv
// Serializer: loads one slot into per-lane 9-bit shift registers and
// shifts them out one bit per clock, start bit first, data LSB first.
// Unused lanes load all ones and stay at idle. Assumes load only when
// ser_free is high.
module blt_slot_serializer
    import blt_pkg::*;
#(
    parameter int LANES = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LANES*8-1:0] slot_bytes,
    input  logic [CW-1:0]      slot_used,
    output logic               ser_free,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic [LANES-1:0]   lane_out
);
    logic [CNT_W-1:0] cnt_q;

    assign bit_cnt  = cnt_q;
    assign ser_free = (cnt_q <= CNT_W'(1));

    // Remaining bit times of the slot on the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CHAR_BITS);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [CHAR_BITS-1:0] sh_q;
            logic                 used;
            assign used = (CW'(g) < slot_used);

            // Per-lane character shifter, filling with idle ones.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q <= '1;
                end else if (load) begin
                    sh_q <= used ? {slot_bytes[g*8 +: 8], 1'b0} : '1;
                end else begin
                    sh_q <= {1'b1, sh_q[CHAR_BITS-1:1]};
                end
            end
            assign lane_out[g] = sh_q[0];
        end
    endgenerate
endmodule

// File: rtl/bonded_lane_tx.sv
// Top: framed byte stream in, LANES bonded serial lanes out.
// Chain: framer (flags, escapes) -> slot packer -> slot serializer.
// Assumes one lane bit per clk and a receiver recovering each lane alone.
module bonded_lane_tx
    import blt_pkg::*;
#(
    parameter int LANES = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic [LANES-1:0] lane_out,
    output logic             busy
);
    logic               st_valid;
    logic [7:0]         st_byte;
    logic               st_close;
    logic               st_ready;
    logic               fr_active;
    logic               ser_free;
    logic               slot_launch;
    logic [LANES*8-1:0] slot_bytes;
    logic [CW-1:0]      pk_count;
    logic               pk_sealed;
    logic [CNT_W-1:0]   ser_cnt;

    blt_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (st_valid),
        .out_byte  (st_byte),
        .out_close (st_close),
        .out_ready (st_ready),
        .active    (fr_active)
    );

    blt_slot_packer #(.LANES(LANES)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (st_valid),
        .in_byte    (st_byte),
        .in_close   (st_close),
        .in_ready   (st_ready),
        .ser_free   (ser_free),
        .launch     (slot_launch),
        .slot_bytes (slot_bytes),
        .slot_used  (pk_count),
        .sealed     (pk_sealed)
    );

    blt_slot_serializer #(.LANES(LANES)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (slot_launch),
        .slot_bytes (slot_bytes),
        .slot_used  (pk_count),
        .ser_free   (ser_free),
        .bit_cnt    (ser_cnt),
        .lane_out   (lane_out)
    );

    assign busy = fr_active || (pk_count != '0) || (ser_cnt != '0);
endmodule

// File: rtl/blt_tx_checker.sv
// Checker: temporal properties across framer, packer and serializer,
// bound into every instance of the top module.
module blt_tx_checker
    import blt_pkg::*;
#(
    parameter int LANES = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] lane_out,
    input logic             busy,
    input logic             in_ready,
    input logic             slot_launch,
    input logic [CW-1:0]    pk_count,
    input logic             pk_sealed,
    input logic [CNT_W-1:0] ser_cnt
);
    // R1: idle lanes whenever nothing is in flight.
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_out == '1));

    // R6: a launched slot always holds at least the lane 0 byte.
    a_r6_slot_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        slot_launch |-> (pk_count != '0));

    // R6: the fill count never passes the lane count.
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pk_count <= CW'(LANES));

    // R8: lane 0 shows its start bit in the cycle after a slot is loaded.
    a_r8_start_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        slot_launch |=> !lane_out[0]);

    // R9: a full slot waiting at the last bit time starts without a gap.
    a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_cnt == CNT_W'(1) && pk_count == CW'(LANES)) |=> (ser_cnt == CNT_W'(CHAR_BITS)));

    // R10: a closed frame blocks new payload until its slot is launched.
    a_r10_sealed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pk_sealed |-> !in_ready);

    // R11: busy only falls once the lanes are back at idle.
    a_r11_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lane_out == '1));
endmodule

bind bonded_lane_tx blt_tx_checker #(.LANES(LANES)) u_blt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_out    (lane_out),
    .busy        (busy),
    .in_ready    (in_ready),
    .slot_launch (slot_launch),
    .pk_count    (pk_count),
    .pk_sealed   (pk_sealed),
    .ser_cnt     (ser_cnt)
);

// File: tb/test_bonded_lane_tx.sv
// Scoreboard bench: the driver pushes the expected stuffed bytes, the
// monitor decodes lane slots and pops and compares them.
module test_bonded_lane_tx;
    localparam int LANES = 8;

    typedef struct {
        logic [7:0] b;
        string      tag;
        bit         opener;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_last = 1'b0;
    logic             in_ready;
    logic [LANES-1:0] lane_out;
    logic             busy;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc      = 0;
    exp_t exp_q[$];
    int   slot_starts[$];
    logic [7:0] pay[$];

    always #2 clk = ~clk;

    bonded_lane_tx #(.LANES(LANES)) i_bonded_lane_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .lane_out (lane_out),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: decode slots at negedge, pop and compare expected bytes.
    int         mon_bit = -1;
    int         mon_used = 0;
    logic [7:0] rx [LANES];
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mon_bit < 0) begin
                if (lane_out != '1) begin
                    logic [LANES-1:0] act;
                    act = ~lane_out;
                    check(act[0], "R8", "lane 0 start bit with others", int'(lane_out), 0);
                    check((act & (act + 1'b1)) == '0, "R6", "used lanes contiguous from 0",
                          int'(act), 0);
                    mon_used = $countones(act);
                    slot_starts.push_back(cyc);
                    mon_bit = 0;
                end
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    rx[k][mon_bit] = lane_out[k];
                    if (k >= mon_used && !lane_out[k]) begin
                        check(1'b0, "R7", "unused lane went low", k, -1);
                    end
                end
                mon_bit++;
                if (mon_bit == 8) begin
                    for (int k = 0; k < mon_used; k++) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R3", "unexpected byte", int'(rx[k]), -1);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            check(rx[k] == e.b, e.tag, "lane byte", int'(rx[k]), int'(e.b));
                            if (e.opener) begin
                                check(k == 0, "R6", "opening flag lane", k, 0);
                            end
                        end
                    end
                    mon_bit = -1;
                end
            end
        end
    end

    // Push expected stuffed bytes of the payload in pay; return their count.
    function automatic int push_expected();
        int n = 2;
        exp_q.push_back('{8'h7E, "R3", 1'b1});
        foreach (pay[i]) begin
            if (pay[i] == 8'h7E) begin
                exp_q.push_back('{8'h7D, "R4", 1'b0});
                exp_q.push_back('{8'h5E, "R4", 1'b0});
                n += 2;
            end else if (pay[i] == 8'h7D) begin
                exp_q.push_back('{8'h7D, "R5", 1'b0});
                exp_q.push_back('{8'h5D, "R5", 1'b0});
                n += 2;
            end else begin
                exp_q.push_back('{pay[i], "R5", 1'b0});
                n += 1;
            end
        end
        exp_q.push_back('{8'h7E, "R3", 1'b0});
        return n;
    endfunction

    // Driver: offer the payload bytes, idling gap cycles between them.
    task automatic drive_frame(input int gap, output int stuffed);
        stuffed = push_expected();
        for (int i = 0; i < pay.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pay[i];
            in_last  = (i == pay.size() - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((busy || exp_q.size() != 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic timing_frame(input int npay);
        int stuffed;
        int slots;
        pay.delete();
        for (int i = 0; i < npay; i++) pay.push_back(8'(i + 1));
        slot_starts.delete();
        drive_frame(0, stuffed);
        wait_idle();
        slots = (stuffed + LANES - 1) / LANES;
        check(slot_starts.size() == slots, "R9", "slot count", slot_starts.size(), slots);
        if (slot_starts.size() == slots) begin
            check(slot_starts[slots-1] - slot_starts[0] + 9 == 9 * slots, "R9",
                  "frame bit times", slot_starts[slots-1] - slot_starts[0] + 9, 9 * slots);
            for (int s = 1; s < slots; s++) begin
                check(slot_starts[s] - slot_starts[s-1] == 9, "R2",
                      "no stop bit between slots", slot_starts[s] - slot_starts[s-1], 9);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int stuffed;
        repeat (4) @(negedge clk);
        check(lane_out == '1, "R1", "lanes in reset", int'(lane_out), 8'hFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(lane_out == '1, "R1", "lanes after reset", int'(lane_out), 8'hFF);
        check(busy == 1'b0, "R11", "busy after reset", busy, 0);

        // R9: 9 payload -> 11 stuffed -> 18 bit times; 17 -> 19 -> 27.
        timing_frame(9);
        timing_frame(17);

        // R7: single byte frame uses three lanes, R10: ready low on opening flag.
        pay.delete();
        pay.push_back(8'h55);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h55;
        in_last  = 1'b1;
        #1;
        check(in_ready == 1'b0, "R10", "ready during opening flag", in_ready, 0);
        @(negedge clk);
        #1;
        check(busy == 1'b1, "R11", "busy after opening flag", busy, 1);
        in_valid = 1'b0;
        drive_frame(0, stuffed);
        wait_idle();
        check(busy == 1'b0, "R11", "busy after frame", busy, 0);

        // R4/R5: escapes of flag and escape bytes among plain bytes.
        pay.delete();
        pay = '{8'h7E, 8'h7D, 8'h7E, 8'h7E, 8'h00, 8'hFF, 8'h20, 8'h5E, 8'h5D, 8'h7D};
        drive_frame(0, stuffed);
        wait_idle();

        // R10: gaps in the payload flush partial slots, nothing lost.
        pay.delete();
        pay = '{8'hA1, 8'h7E, 8'hB2, 8'hC3, 8'h7D, 8'hD4};
        drive_frame(3, stuffed);
        wait_idle();

        // R6: back-to-back frames, each opening flag on lane 0.
        pay.delete();
        pay = '{8'h11, 8'h22, 8'h33};
        drive_frame(0, stuffed);
        pay.delete();
        pay = '{8'h44, 8'h7E};
        drive_frame(0, stuffed);
        wait_idle();

        check(exp_q.size() == 0, "R6", "expected bytes left", exp_q.size(), 0);
        check(lane_out == '1, "R1", "lanes idle at end", int'(lane_out), 8'hFF);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule